// File: doc/BRIEF.md
# External Access Wait-State Generator

This block stretches external bus accesses by a programmable number of wait cycles. A requester presents an access with a space code and an address, and the block holds its ready output low for the number of cycles that software has programmed for that space and address half. The base counts come from five 3-bit fields in a 16-bit timing register. A control register holds one bit that doubles every count.

The access side is a valid/ready handshake. The requester raises `acc_valid` and holds `acc_space` and `acc_addr` stable until it sees `acc_ready` high. The transfer completes on the rising edge where both are high. Holding ready low is the only back-pressure the block applies, so it never drops a request. If `acc_valid` stays high after a completion, the next access starts in the following cycle.

Software reaches both registers through a plain register port with a write strobe and a combinational read. The extended-program-addressing bit in the timing register changes how program addresses are decoded.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset the timing register (address 28h) reads 7FFFh, so every field is 7 and the extended bit is 0, and the control register (address 2Bh) reads 0000h.
- R2: A write to address 28h stores all 16 bits of the timing register, and they read back unchanged.
- R3: At address 2Bh, bit 0 is the doubling bit and can be read and written. Bits 15..1 always read 0 and writes do not change them.
- R4: A data access (space code 1) uses timing bits 8..6 when address bit 15 is 0 and bits 11..9 when it is 1.
- R5: An I/O access (space code 2, with code 3 treated the same way) uses timing bits 14..12 for every address.
- R6: With timing bit 15 at 0, a program access (space code 0) uses bits 2..0 when address bit 15 is 0 and bits 5..3 when it is 1, whatever the address bits above 15.
- R7: With timing bit 15 at 1, every program access uses bits 2..0, including addresses above 3FFFFh, and bits 5..3 have no effect.
- R8: With control bit 0 at 1 the wait count is twice the base field, up to 14. With it at 0 the count equals the field.
- R9: For a wait count N, counted from the first cycle `acc_valid` is high while the block is idle, `acc_ready` is low for N cycles and high in cycle N. N=0 gives `acc_ready` high in the first cycle.
- R10: A register write made while an access is waiting does not change that access's wait count. It does apply to the next access.
- R11: `acc_ready` is never high while `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (28h timing, 2Bh control) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| acc_valid | input | 1 | Access request valid |
| acc_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 I/O |
| acc_addr | input | 20 | Access address |
| acc_ready | output | 1 | Access completes when high together with acc_valid |

## Verification
A wrong field choice, a wrong doubling or a wrong counter load shows as an access whose ready arrives on the wrong cycle. The error becomes visible at most 15 cycles after the access begins. The bench therefore counts the exact number of low-ready cycles for every space, for both address halves, for program addresses above and below the extended range, and for all field values with both settings of the extended and doubling bits. A register that is corrupted or changed by a write it should ignore shows up on the next read or the next access.

// File: rtl/ext_wait_gen_pkg.sv
package ext_wait_gen_pkg;
  typedef enum logic [1:0] {
    SPC_PROG = 2'd0,
    SPC_DATA = 2'd1,
    SPC_IO   = 2'd2,
    SPC_IO2  = 2'd3
  } space_e;

  // field slot index inside the timing register
  localparam int FLD_PLO = 0;
  localparam int FLD_PHI = 1;
  localparam int FLD_DLO = 2;
  localparam int FLD_DHI = 3;
  localparam int FLD_IO  = 4;
  localparam int NUM_FLD = 5;
endpackage

// File: rtl/ext_wait_regs.sv
module ext_wait_regs #(
  parameter int RADDR_W = 8,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 3,
  parameter logic [RADDR_W-1:0] TIM_ADDR  = 8'h28,
  parameter logic [RADDR_W-1:0] CTRL_ADDR = 8'h2B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [RADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [ext_wait_gen_pkg::NUM_FLD*FIELD_W:0] timing,
  output logic               dbl
);
  localparam int TIM_W = ext_wait_gen_pkg::NUM_FLD*FIELD_W + 1;
  localparam logic [TIM_W-1:0] TIM_RST = {1'b0, {(TIM_W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing <= TIM_RST;
      dbl    <= 1'b0;
    end else if (wr) begin
      if (addr == TIM_ADDR)  timing <= wdata[TIM_W-1:0];
      if (addr == CTRL_ADDR) dbl    <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == TIM_ADDR)       rdata[TIM_W-1:0] = timing;
    else if (addr == CTRL_ADDR) rdata[0] = dbl;
  end
endmodule

// File: rtl/ext_wait_decode.sv
module ext_wait_decode #(
  parameter int ADDR_W  = 20,
  parameter int FIELD_W = 3
) (
  input  logic [ext_wait_gen_pkg::NUM_FLD*FIELD_W:0] timing,
  input  logic               dbl,
  input  logic [1:0]         space,
  input  logic [ADDR_W-1:0]  addr,
  output logic [FIELD_W:0]   count
);
  import ext_wait_gen_pkg::*;
  localparam int XBIT = NUM_FLD*FIELD_W;

  logic [FIELD_W-1:0] fld [NUM_FLD];
  logic [FIELD_W-1:0] base;
  logic               half;

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign fld[i] = timing[i*FIELD_W +: FIELD_W];
  end

  assign half = addr[15];

  always_comb begin
    case (space_e'(space))
      SPC_PROG: begin
        // extended mode: one field covers all program addresses
        if (timing[XBIT]) base = fld[FLD_PLO];
        else              base = half ? fld[FLD_PHI] : fld[FLD_PLO];
      end
      SPC_DATA: base = half ? fld[FLD_DHI] : fld[FLD_DLO];
      default:  base = fld[FLD_IO];
    endcase
    count = dbl ? {base, 1'b0} : {1'b0, base};
  end
endmodule

// File: rtl/ext_wait_counter.sv
module ext_wait_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CNT_W-1:0] load,
  output logic             ready
);
  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign ready = valid && (busy ? (cnt == '0) : (load == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (valid && load != '0) begin
        busy <= 1'b1;
        cnt  <= load - 1'b1;
      end
    end else if (cnt == '0) begin
      if (valid) busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ext_wait_gen.sv
module ext_wait_gen #(
  parameter int RADDR_W = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 20,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               acc_valid,
  input  logic [1:0]         acc_space,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               acc_ready
);
  localparam int TIM_W = ext_wait_gen_pkg::NUM_FLD*FIELD_W + 1;
  localparam int CNT_W = FIELD_W + 1;

  logic [TIM_W-1:0] timing;
  logic             dbl;
  logic [CNT_W-1:0] count;

  ext_wait_regs #(.RADDR_W(RADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .timing(timing), .dbl(dbl)
  );

  ext_wait_decode #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_dec (
    .timing(timing), .dbl(dbl), .space(acc_space), .addr(acc_addr), .count(count)
  );

  ext_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .load(count), .ready(acc_ready)
  );
endmodule

// File: rtl/ext_wait_gen_chk.sv
module ext_wait_gen_chk #(
  parameter int RADDR_W = 8,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [RADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               acc_valid,
  input logic               acc_ready
);
  localparam int MAXW = 2 * ((1 << FIELD_W) - 1);
  localparam logic [RADDR_W-1:0] TIM_A  = 8'h28;
  localparam logic [RADDR_W-1:0] CTRL_A = 8'h2B;

  int wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !acc_valid || acc_ready) wcnt <= 0;
    else                                   wcnt <= wcnt + 1;
  end

  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> acc_valid);

  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= MAXW);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_A) |-> (reg_rdata[DATA_W-1:1] == '0));

  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTRL_A) |=>
      (reg_addr != CTRL_A || reg_rdata[0] == $past(reg_wdata[0])));

  a_r2_timing_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == TIM_A) |=>
      (reg_addr != TIM_A || reg_rdata == $past(reg_wdata)));
endmodule

bind ext_wait_gen ext_wait_gen_chk #(.RADDR_W(RADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .acc_valid(acc_valid), .acc_ready(acc_ready)
);

// File: tb/ext_wait_gen_tb.sv
module ext_wait_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_space = 2'd0;
  logic [19:0] acc_addr = 20'h0;
  logic        acc_ready;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ext_wait_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_ready(acc_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // expected wait count from the requirements
  function automatic int exp_wait(input logic [15:0] tim, input logic dbl,
                                  input logic [1:0] sp, input logic [19:0] ad);
    int b;
    if (sp == 2'd0)      b = tim[15] ? int'(tim[2:0]) : (ad[15] ? int'(tim[5:3]) : int'(tim[2:0]));
    else if (sp == 2'd1) b = ad[15] ? int'(tim[11:9]) : int'(tim[8:6]);
    else                 b = int'(tim[14:12]);
    return dbl ? 2*b : b;
  endfunction

  // run one access; returns number of cycles ready stayed low
  task automatic run_acc(input logic [1:0] sp, input logic [19:0] ad, output int n);
    @(negedge clk);
    acc_valid = 1'b1; acc_space = sp; acc_addr = ad;
    n = 0;
    #1;
    while (!acc_ready && n < 40) begin
      @(negedge clk);
      #1;
      n++;
    end
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [19:0] addrs [13];
  logic [1:0]  spcs  [13];

  initial begin
    logic [15:0] d;
    int n;
    addrs[0]=20'h00000; spcs[0]=2'd0;  addrs[1]=20'h07FFF; spcs[1]=2'd0;
    addrs[2]=20'h08000; spcs[2]=2'd0;  addrs[3]=20'h0FFFF; spcs[3]=2'd0;
    addrs[4]=20'h3FFFF; spcs[4]=2'd0;  addrs[5]=20'h48000; spcs[5]=2'd0;
    addrs[6]=20'hF8000; spcs[6]=2'd0;  addrs[7]=20'h00000; spcs[7]=2'd1;
    addrs[8]=20'h07FFF; spcs[8]=2'd1;  addrs[9]=20'h08000; spcs[9]=2'd1;
    addrs[10]=20'h0FFFF; spcs[10]=2'd2; addrs[11]=20'h00000; spcs[11]=2'd2;
    addrs[12]=20'h08000; spcs[12]=2'd3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_reg(8'h28, d); chk("R1 timing reset", d, 16'h7FFF);
    rd_reg(8'h2B, d); chk("R1 ctrl reset", d, 16'h0000);
    run_acc(2'd1, 20'h0, n); chk("R1 R9 slowest after reset", n, 7);

    // R11 idle: ready low without valid
    @(negedge clk); #1 chk("R11 no ready when idle", acc_ready, 0);

    // R2 / R3 register behaviour
    wr_reg(8'h28, 16'hA5C3); rd_reg(8'h28, d); chk("R2 timing readback", d, 16'hA5C3);
    wr_reg(8'h2B, 16'hFFFF); rd_reg(8'h2B, d); chk("R3 ctrl reserved ignored", d, 16'h0001);
    wr_reg(8'h2B, 16'hFFFE); rd_reg(8'h2B, d); chk("R3 ctrl bit0 clear", d, 16'h0000);

    // sweep R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 8; v++) begin
      for (int x = 0; x < 2; x++) begin
        for (int m = 0; m < 2; m++) begin
          logic [15:0] tim;
          tim = {x[0], 3'((v+4)%8), 3'((v+3)%8), 3'((v+2)%8), 3'((v+1)%8), 3'(v)};
          wr_reg(8'h28, tim);
          wr_reg(8'h2B, {15'h0, m[0]});
          for (int k = 0; k < 13; k++) begin
            run_acc(spcs[k], addrs[k], n);
            if (spcs[k] == 2'd1)      chk("R4 R8 R9 data wait", n, exp_wait(tim, m[0], spcs[k], addrs[k]));
            else if (spcs[k] != 2'd0) chk("R5 R8 R9 io wait", n, exp_wait(tim, m[0], spcs[k], addrs[k]));
            else if (x == 0)          chk("R6 R8 R9 program wait", n, exp_wait(tim, m[0], spcs[k], addrs[k]));
            else                      chk("R7 R8 R9 extended program wait", n, exp_wait(tim, m[0], spcs[k], addrs[k]));
          end
        end
      end
    end

    // R8 maximum of 14 cycles
    wr_reg(8'h28, 16'h7FFF); wr_reg(8'h2B, 16'h0001);
    run_acc(2'd2, 20'h1234, n); chk("R8 max doubled", n, 14);

    // R10 writes during an access
    wr_reg(8'h28, 16'h0000); wr_reg(8'h2B, 16'h0000);
    wr_reg(8'h28, 16'h0A00); // data upper = 5
    @(negedge clk);
    acc_valid = 1'b1; acc_space = 2'd1; acc_addr = 20'h08000;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 16'h0000;
    @(negedge clk);
    reg_addr = 8'h2B; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_wr = 1'b0;
    n = 3;
    #1;
    while (!acc_ready && n < 40) begin
      @(negedge clk); #1 n++;
    end
    chk("R10 in-flight count kept", n, 5);
    @(negedge clk); acc_valid = 1'b0;
    run_acc(2'd1, 20'h08000, n); chk("R10 next access uses new", n, 0);

    // R11 ready drops with valid
    @(negedge clk); #1 chk("R11 ready low after valid drop", acc_ready, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule